// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiplier

This unit multiplies two 8-bit register operands and produces a 16-bit product for a small RISC core. The product is split into a high byte and a low byte, written to a fixed destination register pair. A two-bit signedness select picks one of three modes: unsigned by unsigned, signed by signed, or signed first operand by unsigned second operand. A separate fractional enable shifts the product left by one bit, which gives six usable operations in total.

A one-cycle `start` pulse launches an operation. Every operation takes exactly two clock cycles. When the result is ready, `res_vld` pulses for one cycle. At the same time the unit updates the zero and carry flags. The core merges these two flags into its status register and leaves the other status flags alone. While the unit is busy it ignores a new `start`. Between operations the result and flags keep their last values.

Top module: `mul8x8_unit`

## Requirements
- R1: With `sign_mode` = 2'b00, both operands are unsigned, and {`res_hi`,`res_lo`} is the low 16 bits of their product.
- R2: With `sign_mode` = 2'b01, both operands are two's-complement signed, and the result is the 16-bit two's-complement product.
- R3: With `sign_mode` = 2'b10, `op_a` is signed and `op_b` is unsigned, and the result is the 16-bit two's-complement product.
- R4: With `sign_mode` = 2'b11, the unit behaves exactly as in unsigned mode (2'b00).
- R5: With `frac_en` = 1, the result is the 16-bit product of the selected mode shifted left by one bit, so bit 0 is 0.
- R6: `flag_c` equals bit 15 of the product before any fractional shift.
- R7: `flag_z` is 1 exactly when all 16 result bits, after any shift, are zero.
- R8: A `start` sampled while the unit is idle produces a one-cycle `res_vld` after the second rising edge that follows it. `busy` is high for the cycle in between.
- R9: A `start` sampled while `busy` is high is ignored. It produces no `res_vld`, and its operands never appear in the result.
- R10: The result and flags change only when `res_vld` rises, and otherwise hold their previous values.
- R11: After reset, the result and flags are zero and `res_vld` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch a multiply |
| op_a | input | 8 | First operand (signed in modes 01 and 10) |
| op_b | input | 8 | Second operand (signed in mode 01) |
| sign_mode | input | 2 | 00 uu, 01 ss, 10 su, 11 uu |
| frac_en | input | 1 | Shift product left by one |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| res_vld | output | 1 | Result ready pulse |
| busy | output | 1 | Operation in progress |

## Verification
A `start` is sampled on rising edge E0, and `busy` is visible after E0. On E1 the result, both flags and `res_vld` change together. After E2, `res_vld` is low again and the outputs hold. The bench drives inputs on falling edges and checks at the falling edge after each of E0, E1 and E2. To test R9, it holds `start` high across E1 and then confirms that no pulse follows E2.

// File: rtl/mul8x8_unit.sv
module mul8x8_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   sign_mode,
  input  logic         frac_en,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         flag_z,
  output logic         flag_c,
  output logic         res_vld,
  output logic         busy
);
  localparam int PW = 2 * W;

  logic [W-1:0]        a_q, b_q;
  logic [1:0]          sm_q;
  logic                frac_q;
  logic signed [W:0]   ax, bx;
  logic signed [PW+1:0] full;
  logic [PW-1:0]       raw, shaped;

  assign ax     = {((sm_q == 2'b01) || (sm_q == 2'b10)) & a_q[W-1], a_q};
  assign bx     = {(sm_q == 2'b01) & b_q[W-1], b_q};
  assign full   = ax * bx;
  assign raw    = full[PW-1:0];
  assign shaped = frac_q ? {raw[PW-2:0], 1'b0} : raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      sm_q    <= '0;
      frac_q  <= 1'b0;
      busy    <= 1'b0;
      res_vld <= 1'b0;
      res_hi  <= '0;
      res_lo  <= '0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
    end else begin
      res_vld <= 1'b0;
      if (busy) begin
        busy    <= 1'b0;
        res_vld <= 1'b1;
        {res_hi, res_lo} <= shaped;
        flag_c  <= raw[PW-1];
        flag_z  <= (shaped == '0);
      end else if (start) begin
        a_q    <= op_a;
        b_q    <= op_b;
        sm_q   <= sign_mode;
        frac_q <= frac_en;
        busy   <= 1'b1;
      end
    end
  end

  // R8
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R8
  busy_to_vld_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (res_vld && !busy));
  // R8
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld);
  // R9
  vld_source_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(busy));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> ($stable(res_hi) && $stable(res_lo) && $stable(flag_z) && $stable(flag_c)));
  // R5
  frac_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && frac_q) |-> (res_lo[0] == 1'b0));
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (flag_z == ({res_hi, res_lo} == '0)));
endmodule

// File: tb/test_mul8x8_unit.sv
module test_mul8x8_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [1:0] sign_mode = '0;
  logic       frac_en = 1'b0;
  logic [7:0] res_hi, res_lo;
  logic       flag_z, flag_c, res_vld, busy;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mul8x8_unit i_mul8x8_unit (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .sign_mode(sign_mode), .frac_en(frac_en), .res_hi(res_hi), .res_lo(res_lo),
    .flag_z(flag_z), .flag_c(flag_c), .res_vld(res_vld), .busy(busy)
  );

  // returns {carry, zero, result}
  function automatic logic [17:0] model(logic [7:0] a, logic [7:0] b, logic [1:0] sm, logic fr);
    int va, vb, p;
    logic [15:0] r;
    logic c;
    va = ((sm == 2'b01 || sm == 2'b10) && a[7]) ? int'(a) - 256 : int'(a);
    vb = (sm == 2'b01 && b[7]) ? int'(b) - 256 : int'(b);
    p = va * vb;
    r = p[15:0];
    c = r[15];
    if (fr) r = {r[14:0], 1'b0};
    return {c, (r == 16'h0), r};
  endfunction

  function automatic string mode_tag(logic [1:0] sm, logic fr);
    string s;
    case (sm)
      2'b00: s = "R1";
      2'b01: s = "R2";
      2'b10: s = "R3";
      default: s = "R4";
    endcase
    if (fr) s = {s, "/R5"};
    return s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [7:0] a, logic [7:0] b, logic [1:0] sm, logic fr);
    logic [17:0] e;
    e = model(a, b, sm, fr);
    op_a = a; op_b = b; sign_mode = sm; frac_en = fr; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(busy && !res_vld, "R8 busy after start", {busy, res_vld}, 2'b10);
    @(posedge clk); @(negedge clk);
    chk(res_vld, "R8 valid on second edge", res_vld, 1);
    chk({res_hi, res_lo} == e[15:0], mode_tag(sm, fr), {res_hi, res_lo}, e[15:0]);
    chk(flag_c == e[17], "R6 carry", flag_c, e[17]);
    chk(flag_z == e[16], "R7 zero", flag_z, e[16]);
    @(posedge clk); @(negedge clk);
    chk(!res_vld && {res_hi, res_lo} == e[15:0], "R10 hold after pulse", {res_vld, res_hi, res_lo}, e[15:0]);
  endtask

  initial begin
    logic [7:0] corners [5];
    logic [17:0] e;
    void'($urandom(32'd5813));
    corners[0] = 8'h00; corners[1] = 8'h80; corners[2] = 8'hFF;
    corners[3] = 8'h01; corners[4] = 8'h7F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk({res_hi, res_lo, flag_z, flag_c, res_vld, busy} == '0, "R11 reset state",
        {res_hi, res_lo, flag_z, flag_c, res_vld, busy}, 0);

    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            run_op(corners[i], corners[j], m[1:0], f[0]);

    run_op(8'h00, 8'h5A, 2'b01, 1'b0);
    chk(flag_z == 1'b1, "R7 zero operand", flag_z, 1);
    run_op(8'h80, 8'h80, 2'b01, 1'b1);
    chk({res_hi, res_lo} == 16'h8000 && !flag_c, "R5 frac 0x80*0x80", {res_hi, res_lo}, 16'h8000);

    // R9: start held across busy cycle
    e = model(8'h12, 8'h34, 2'b00, 1'b0);
    op_a = 8'h12; op_b = 8'h34; sign_mode = 2'b00; frac_en = 1'b0; start = 1'b1;
    @(posedge clk); @(negedge clk);
    op_a = 8'hFF; op_b = 8'hFF; sign_mode = 2'b01;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(res_vld && {res_hi, res_lo} == e[15:0], "R9 first result kept", {res_hi, res_lo}, e[15:0]);
    @(posedge clk); @(negedge clk);
    chk(!res_vld && !busy, "R9 busy start ignored", {res_vld, busy}, 0);
    @(posedge clk); @(negedge clk);
    chk(!res_vld && {res_hi, res_lo} == e[15:0], "R9 no late result", {res_hi, res_lo}, e[15:0]);

    repeat (400) begin
      logic [7:0] ra, rb;
      logic [1:0] rm;
      ra = 8'($urandom); rb = 8'($urandom); rm = 2'($urandom);
      run_op(ra, rb, rm, 1'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++;
          failures++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule